// File: doc/BRIEF.md
# Dual-Word Serial Control Register

This block receives 8-bit control words over a serial link, most significant bit first, and keeps the settings of a display driver in two control words. A frame runs for as long as `frame_en` is high. The register-select input `ctl_sel` is sampled on the first clock of the frame, and the block shifts one bit per clock while the frame lasts. When `frame_en` falls, the block commits the received word, but only if the bit count is a nonzero multiple of eight. Bit 7 of the word chooses its destination. Word 0 sets the sleep/run bit, the peak-current code and the PWM brightness code. Word 1 sets the data-out mode and the external-oscillator divide-by-8 selection.

The serial output `ser_out` lets several devices share one bus. In chained mode it carries the last stage of the shift register, so N devices load in N×8 clocks. In simultaneous mode it passes `ser_in` straight through during a control frame, so N devices take the same word in 8 clocks. Frames with `ctl_sel` low are meant for a dot path outside this block. They leave the control state untouched.

The sequencer has four states:
- `ST_IDLE`: no frame.
- `ST_PARTIAL`: a control frame that is not on a byte boundary.
- `ST_ALIGNED`: a control frame holding a whole number of bytes.
- `ST_IGNORE`: a non-control frame.

Transitions:
- IDLE→PARTIAL when the frame starts with select high.
- IDLE→IGNORE when the frame starts with select low.
- PARTIAL→ALIGNED on the eighth bit of a byte.
- ALIGNED→PARTIAL on the next bit.
- ALIGNED→IDLE with a commit when the frame ends.
- PARTIAL→IDLE without a commit when the frame ends.
- IGNORE→IDLE when the frame ends.

Top module: `ctl_serial_regs`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the following to 0: `awake`, `peak_code` (00, the 73 % level), `pwm_code` (0000), `osc_div8` and `simul_out`. It also clears the shift register, so `ser_out` reads 0 after reset.
- R2: A control frame of exactly 8 bits whose first bit (bit 7) is 0 is committed as word 0 at the clock edge where `frame_en` is first sampled low. The fields take these bits: `awake` from bit 6, `peak_code` from bits 5:4, `pwm_code` from bits 3:0.
- R3: A committed word whose bit 7 is 1 sets `simul_out` from bit 0 and `osc_div8` from bit 1. Bits 6:2 are ignored, and the word-0 fields keep their values.
- R4: A control frame whose bit count is not a nonzero multiple of 8 changes no output field.
- R5: A control frame of 8·k bits (k ≥ 2) commits the last 8 bits received.
- R6: `ctl_sel` counts only on the first clock of a frame. A frame that starts with it low changes no field and leaves the shift register, as seen on `ser_out`, unchanged. Later changes of `ctl_sel` within a frame have no effect.
- R7: When `simul_out` is 0, or outside a control frame, `ser_out` equals the bit that entered the shift register eight shifts earlier (its bit 7).
- R8: When `simul_out` is 1, `ser_out` equals `ser_in` combinationally on every clock of a control frame, including the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; data sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data in, MSB first |
| frame_en | input | 1 | High for the duration of a frame |
| ctl_sel | input | 1 | High on the first clock selects the control register |
| ser_out | output | 1 | Serial data out (chain tap or pass-through) |
| awake | output | 1 | 1 = normal operation, 0 = sleep |
| peak_code | output | 2 | Peak-current code |
| pwm_code | output | 4 | PWM brightness code |
| osc_div8 | output | 1 | External oscillator divided by 8 when 1 |
| simul_out | output | 1 | 1 = simultaneous data-out mode |

## Verification
The hardest condition to reach is the pass-through window. Reaching it takes three steps: a word-1 frame must first set the mode, a later frame must start with select high, and the check must happen before the clock edge while `ser_in` is still moving. The stimulus sets the mode with a directed frame. It then runs seeded random frames whose lengths are 8, 16 or 24 bits, or misaligned. Within those frames `ctl_sel` toggles after the first bit. The bench model checks `ser_out` before each edge, so the combinational path and the eight-stage tap are both observed under both modes.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    localparam int WORD_W = 8;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PARTIAL,
        ST_ALIGNED,
        ST_IGNORE
    } seq_state_t;

    // Word 0 fields
    typedef struct packed {
        logic       awake;
        logic [1:0] peak;
        logic [3:0] pwm;
    } word0_t;

    // Word 1 fields
    typedef struct packed {
        logic div8;
        logic simul;
    } word1_t;
endpackage

// File: rtl/ctl_frame_seq.sv
module ctl_frame_seq
    import ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_en,
    input  logic ctl_sel,
    output logic shift_en,
    output logic commit
);
    seq_state_t         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_en) begin
                    if (ctl_sel) begin
                        state_d = ST_PARTIAL;
                        cnt_d   = CNT_W'(1);
                    end else begin
                        state_d = ST_IGNORE;
                    end
                end
            end
            ST_PARTIAL: begin
                if (!frame_en) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_W'(WORD_W - 1)) begin
                    state_d = ST_ALIGNED;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_ALIGNED: begin
                if (!frame_en) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_PARTIAL;
                    cnt_d   = CNT_W'(1);
                end
            end
            ST_IGNORE: begin
                if (!frame_en) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        shift_en = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_IDLE:    shift_en = frame_en && ctl_sel;
            ST_PARTIAL: shift_en = frame_en;
            ST_ALIGNED: begin
                shift_en = frame_en;
                commit   = !frame_en;
            end
            ST_IGNORE:  shift_en = 1'b0;
            default:    shift_en = 1'b0;
        endcase
    end

    // A commit only happens on the edge where the frame has just ended
    assert_commit_on_end_R2: assert property (@(posedge clk) disable iff (rst)
        commit |-> (!frame_en && $past(frame_en)));
endmodule

// File: rtl/ctl_shifter.sv
module ctl_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (en)  q <= {q[W-2:0], d};
    end

    assert_tap_advance_R7: assert property (@(posedge clk) disable iff (rst)
        en |=> (q[W-1] == $past(q[W-2])));

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));
endmodule

// File: rtl/ctl_word_bank.sv
module ctl_word_bank
    import ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    output word0_t            w0,
    output word1_t            w1
);
    localparam int SEL_BIT = WORD_W - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            w0 <= '0;
            w1 <= '0;
        end else if (commit) begin
            if (word[SEL_BIT]) begin
                w1.simul <= word[0];
                w1.div8  <= word[1];
            end else begin
                w0 <= word0_t'(word[SEL_BIT-1:0]);
            end
        end
    end

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    assert_reset_defaults_R1: assert property (@(posedge clk)
        rst_d |-> (w0 == '0 && w1 == '0));

    assert_no_commit_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(w0) && $stable(w1)));
endmodule

// File: rtl/ctl_serial_regs.sv
module ctl_serial_regs
    import ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_in,
    input  logic       frame_en,
    input  logic       ctl_sel,
    output logic       ser_out,
    output logic       awake,
    output logic [1:0] peak_code,
    output logic [3:0] pwm_code,
    output logic       osc_div8,
    output logic       simul_out
);
    logic              shift_en;
    logic              commit;
    logic [WORD_W-1:0] sh_q;
    word0_t            w0;
    word1_t            w1;

    ctl_frame_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .frame_en (frame_en),
        .ctl_sel  (ctl_sel),
        .shift_en (shift_en),
        .commit   (commit)
    );

    ctl_shifter #(.W(WORD_W)) u_sh (
        .clk (clk),
        .rst (rst),
        .en  (shift_en),
        .d   (ser_in),
        .q   (sh_q)
    );

    ctl_word_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .word   (sh_q),
        .w0     (w0),
        .w1     (w1)
    );

    // Pass-through only inside a control frame in simultaneous mode
    assign ser_out   = (w1.simul && shift_en) ? ser_in : sh_q[WORD_W-1];
    assign awake     = w0.awake;
    assign peak_code = w0.peak;
    assign pwm_code  = w0.pwm;
    assign osc_div8  = w1.div8;
    assign simul_out = w1.simul;
endmodule

// File: tb/sim_ctl_serial_regs.sv
module sim_ctl_serial_regs;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1, ser_in = 1'b0, frame_en = 1'b0, ctl_sel = 1'b0;
    logic       ser_out, awake, osc_div8, simul_out;
    logic [1:0] peak_code;
    logic [3:0] pwm_code;

    int total = 0, bad = 0;
    bit finished = 0;

    // reference model state
    logic [7:0] m_sh = '0;
    logic       m_awake = 0, m_div8 = 0, m_simul = 0;
    logic [1:0] m_peak = '0;
    logic [3:0] m_pwm = '0;

    ctl_serial_regs u0 (
        .clk(clk), .rst(rst), .ser_in(ser_in), .frame_en(frame_en), .ctl_sel(ctl_sel),
        .ser_out(ser_out), .awake(awake), .peak_code(peak_code), .pwm_code(pwm_code),
        .osc_div8(osc_div8), .simul_out(simul_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_fields();
        return {23'd0, m_awake, m_peak, m_pwm, m_div8, m_simul};
    endfunction

    function automatic logic [31:0] act_fields();
        return {23'd0, awake, peak_code, pwm_code, osc_div8, simul_out};
    endfunction

    function automatic logic commits(input int n, input logic sel);
        return sel && (n > 0) && (n % 8 == 0);
    endfunction

    task automatic model_commit();
        if (m_sh[7]) begin
            m_simul = m_sh[0];
            m_div8  = m_sh[1];
        end else begin
            m_awake = m_sh[6];
            m_peak  = m_sh[5:4];
            m_pwm   = m_sh[3:0];
        end
    endtask

    // Send n bits (MSB of the n-bit value first); select sampled on bit 0
    task automatic send(input logic [31:0] bits, input int n, input logic sel,
                        input logic jitter_sel, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_en = 1'b1;
            ser_in   = bits[n-1-i];
            ctl_sel  = (i == 0 || !jitter_sel) ? sel : logic'($urandom % 2);
            #1;
            if (m_simul && sel) chk("R8 pass-through", ser_out, ser_in);
            else                chk("R7 chain tap", ser_out, m_sh[7]);
            @(posedge clk);
            if (sel) m_sh = {m_sh[6:0], ser_in};
        end
        @(negedge clk);
        frame_en = 1'b0;
        ctl_sel  = logic'($urandom % 2);
        ser_in   = logic'($urandom % 2);
        @(posedge clk);
        if (commits(n, sel)) model_commit();
        @(negedge clk);
        #1;
        chk(req, act_fields(), exp_fields());
        chk("R6 R7 idle tap", ser_out, m_sh[7]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int lens[6];
        seed = $urandom(32'd4242);
        lens = '{8, 16, 24, 7, 9, 3};

        // R1: reset
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 fields", act_fields(), 32'd0);
        chk("R1 ser_out", ser_out, 1'b0);

        // R2: word 0 with awake=1, peak=10, pwm=1011
        send(32'b0_1_10_1011, 8, 1'b1, 1'b0, "R2 word0");
        // R3: divide-by-8 on, then reserved bits set with mode bit
        send(32'b1_00000_1_0, 8, 1'b1, 1'b0, "R3 word1 div8");
        send(32'b1_11111_0_1, 8, 1'b1, 1'b0, "R3 reserved ignored");
        // R8: simultaneous mode, word 0 frame passes data through
        send(32'b0_0_11_0110, 8, 1'b1, 1'b0, "R8 R2 simul word0");
        // R6: non-control frame in simultaneous mode with select toggling
        send(32'hA5, 8, 1'b0, 1'b1, "R6 dot frame");
        // R6: control frame with select jittering after the first bit
        send(32'b0_1_01_1100, 8, 1'b1, 1'b1, "R6 sel latched");
        // R4: misaligned frames are discarded
        send(32'h3F, 7, 1'b1, 1'b0, "R4 seven bits");
        send(32'h0FF, 9, 1'b1, 1'b0, "R4 nine bits");
        // R5: 16 bits commits the last 8 (word 1: chained mode, div8)
        send(32'h00_82, 16, 1'b1, 1'b0, "R5 sixteen bits");
        send(32'h7F_00_4F, 24, 1'b1, 1'b0, "R5 twenty-four bits");

        // Random frames
        for (int k = 0; k < 80; k++) begin
            int n;
            logic sel;
            n   = lens[$urandom % 6];
            sel = ($urandom % 5) != 0;
            send($urandom, n, sel, 1'b1, "R2 R3 R4 R5 random");
        end

        // Reset mid-operation returns defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_sh = '0; m_awake = 0; m_peak = '0; m_pwm = '0; m_div8 = 0; m_simul = 0;
        #1;
        chk("R1 re-reset", act_fields(), 32'd0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule